// File: doc/BRIEF.md
# UART Register Bank with Interrupt Logic

This block is the software-visible face of a UART. It sits on a simple 32-bit bus with byte addresses. Bits [11:2] of the address select one 32-bit register. The block holds the UART configuration values and the interrupt state. It steers the data register toward the transmit and receive paths, and it drives one level-sensitive interrupt. The serial shifters and the FIFO storage sit outside. The block reports their status through the flag register, and it tells them about a transmit, a pop or a flush with strobes.

A bus access is accepted in any cycle where `bus_sel` is high. Read data is registered and appears with `bus_rvalid` one cycle after the read is accepted. A read of the data register pops the receive FIFO in the same cycle as the access. Writes take effect at the clock edge that accepts them. The top 32 bytes of the 4 KB window return fixed identification bytes.

Top module: `uart_regbank`

## Requirements
- R1: Register index = address bits [11:2]. The following registers read back the last value written to them: index 8 low-power divisor, 9 integer divisor, 10 fractional divisor, 11 line control, 12 control, 13 FIFO level select, 18 DMA control (all 32 bits), and 14 interrupt mask (bits [10:0]). Each value also drives its matching `cfg_*` output.
- R2: After reset, index 13 reads 0x12 and index 12 reads 0x300. The flag register reads 0x90 while `tx_empty`=1, `tx_full`=0 and `rx_count`=0. Every other register and output reads 0.
- R3: A read at a byte address A from 0xFE0 to 0xFFF returns byte (A-0xFE0)>>2 of the table 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, zero-extended.
- R4: Reads of indexes that are not defined, and of unused addresses, return 0. Writes to them change nothing. Writes to the raw (15) and masked (16) status indexes are ignored.
- R5: A write to index 0 pulses `tx_strobe` for one cycle, with `tx_byte` = write data [7:0], in the cycle after the write. It also sets raw status bit 5 (TX).
- R6: Each high bit of `evt_set` sets the matching raw status bit. Bit 4 is RX. A data read while `rx_count`==1 clears raw bit 4, unless `evt_set[4]` is high in that same cycle.
- R7: A read of index 0 returns `rx_data` (bits [7:0] are the byte, bits [11:8] are the error flags). It pulses `rx_pop` in that same cycle only when `rx_count` is nonzero. It latches bits [11:8] into the receive status register (index 1, bits [3:0]).
- R8: Any write to index 1 clears the receive status register.
- R9: The flag register (index 6) holds `tx_empty` at bit 7, RX-full at bit 6, `tx_full` at bit 5 and RX-empty (`rx_count`==0) at bit 4. RX-full means `rx_count`==FIFO_DEPTH when line-control bit 4 is set, and `rx_count`>=1 when it is clear. Writes to index 6 are ignored.
- R10: A write to index 17 clears every raw status bit that is 1 in the write data. Index 15 reads the raw bits. Index 16 reads raw AND mask.
- R11: `irq` is a register. It equals the OR of (raw AND mask) as they stood one cycle earlier.
- R12: A write to index 11 that changes bit 4 pulses `fifo_flush` for one cycle, in the cycle after the write. A write that leaves bit 4 unchanged does not.
- R13: `bus_rvalid` is high exactly one cycle after each accepted read, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| tx_strobe | output | 1 | Byte handed to transmitter |
| tx_byte | output | 8 | Transmit byte |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_full | input | 1 | Transmit FIFO full |
| rx_data | input | 12 | Head of receive FIFO: error flags and byte |
| rx_count | input | 5 | Receive FIFO occupancy |
| rx_pop | output | 1 | Pop receive FIFO |
| evt_set | input | 11 | Raw interrupt set pulses from the engines |
| fifo_flush | output | 1 | FIFO enable toggled, flush FIFOs |
| cfg_ilpr | output | 32 | Low-power divisor |
| cfg_ibrd | output | 32 | Integer baud divisor |
| cfg_fbrd | output | 32 | Fractional baud divisor |
| cfg_lcr | output | 32 | Line control |
| cfg_cr | output | 32 | Control |
| cfg_ifls | output | 32 | FIFO level select |
| cfg_dmacr | output | 32 | DMA control |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the RX-bit clear rule: a pop with several entries left must keep bit 4, and only the pop of the last entry may clear it. A design that cleared the bit on every data read would lose pending-data interrupts. RX-full is checked with the FIFO enabled and disabled, so a design that ignored line-control bit 4 would report full at the wrong occupancy. It also checks the one-cycle lag of `irq` after mask and clear writes. Finally, it confirms that writes to the flag, status and unused offsets leave every readable value unchanged, and that `rx_pop` stays low on an empty FIFO, where a careless design would underflow it.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
  // register indexes (byte address / 4)
  localparam int IDX_DATA  = 0;
  localparam int IDX_RSR   = 1;
  localparam int IDX_FLAG  = 6;
  localparam int IDX_ILPR  = 8;
  localparam int IDX_IBRD  = 9;
  localparam int IDX_FBRD  = 10;
  localparam int IDX_LCR   = 11;
  localparam int IDX_CR    = 12;
  localparam int IDX_IFLS  = 13;
  localparam int IDX_IMSC  = 14;
  localparam int IDX_RIS   = 15;
  localparam int IDX_MIS   = 16;
  localparam int IDX_ICR   = 17;
  localparam int IDX_DMACR = 18;
  localparam int NUM_IDX   = 19;

  // raw interrupt bit positions
  localparam int BIT_RX = 4;
  localparam int BIT_TX = 5;

  // plain configuration slots
  localparam int NUM_CFG   = 7;
  localparam int CFG_ILPR  = 0;
  localparam int CFG_IBRD  = 1;
  localparam int CFG_FBRD  = 2;
  localparam int CFG_LCR   = 3;
  localparam int CFG_CR    = 4;
  localparam int CFG_IFLS  = 5;
  localparam int CFG_DMACR = 6;

  localparam int LCR_FIFO_EN = 4;

  function automatic int cfg_index(input int slot);
    case (slot)
      CFG_ILPR:  return IDX_ILPR;
      CFG_IBRD:  return IDX_IBRD;
      CFG_FBRD:  return IDX_FBRD;
      CFG_LCR:   return IDX_LCR;
      CFG_CR:    return IDX_CR;
      CFG_IFLS:  return IDX_IFLS;
      default:   return IDX_DMACR;
    endcase
  endfunction

  function automatic logic [31:0] cfg_reset(input int slot);
    case (slot)
      CFG_IFLS: return 32'h12;
      CFG_CR:   return 32'h300;
      default:  return 32'h0;
    endcase
  endfunction

  function automatic logic [7:0] id_byte(input logic [2:0] k);
    case (k)
      3'd0: return 8'h11;
      3'd1: return 8'h10;
      3'd2: return 8'h14;
      3'd3: return 8'h00;
      3'd4: return 8'h0D;
      3'd5: return 8'hF0;
      3'd6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/uart_regbank_decode.sv
module uart_regbank_decode
  import uart_regbank_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_IDX-1:0] wr_hit,
  output logic [NUM_IDX-1:0] rd_hit,
  output logic               id_hit,
  output logic [2:0]         id_sel
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             unused_lsb;

  assign idx        = addr[ADDR_W-1:2];
  assign unused_lsb = ^addr[1:0];

  for (genvar g = 0; g < NUM_IDX; g++) begin : g_hit
    assign wr_hit[g] = sel &  wr & (idx == IDX_W'(g));
    assign rd_hit[g] = sel & ~wr & (idx == IDX_W'(g));
  end

  // identification window: the top 32 bytes of the address space
  assign id_hit = sel & ~wr & (&addr[ADDR_W-1:5]);
  assign id_sel = addr[4:2];

  a_r1_one_write_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_hit));
  a_r3_id_excl: assert property (@(posedge clk) disable iff (rst)
    id_hit |-> (rd_hit == '0));
endmodule

// File: rtl/uart_regbank_cfg.sv
module uart_regbank_cfg
  import uart_regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_CFG-1:0]             wr_en,
  input  logic [DATA_W-1:0]              wdata,
  output logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q,
  output logic                           fifo_flush
);
  for (genvar c = 0; c < NUM_CFG; c++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst)           cfg_q[c] <= DATA_W'(cfg_reset(c));
      else if (wr_en[c]) cfg_q[c] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) fifo_flush <= 1'b0;
    else     fifo_flush <= wr_en[CFG_LCR] &
                           (wdata[LCR_FIFO_EN] != cfg_q[CFG_LCR][LCR_FIFO_EN]);
  end

  a_r12_flush_on_toggle: assert property (@(posedge clk) disable iff (rst)
    fifo_flush |-> (cfg_q[CFG_LCR][LCR_FIFO_EN] != $past(cfg_q[CFG_LCR][LCR_FIFO_EN])));
  a_r1_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en == '0) |=> $stable(cfg_q));
endmodule

// File: rtl/uart_regbank_irq.sv
module uart_regbank_irq
  import uart_regbank_pkg::*;
#(
  parameter int IRQ_W = 11,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mask_wr,
  input  logic             clr_wr,
  input  logic             tx_wr,
  input  logic             data_rd,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [IRQ_W-1:0] evt_set,
  input  logic [IRQ_W-1:0] wval,
  output logic [IRQ_W-1:0] raw_q,
  output logic [IRQ_W-1:0] mask_q,
  output logic             irq_o
);
  logic [IRQ_W-1:0] raw_n;

  // clears first, then sets, so a set in the same cycle wins
  always_comb begin
    raw_n = raw_q;
    if (clr_wr) raw_n = raw_n & ~wval;
    if (data_rd && rx_count == CNT_W'(1)) raw_n[BIT_RX] = 1'b0;
    raw_n = raw_n | evt_set;
    if (tx_wr) raw_n[BIT_TX] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      raw_q <= raw_n;
      if (mask_wr) mask_q <= wval;
      irq_o <= |(raw_q & mask_q);
    end
  end

  a_r5_tx_sets_raw: assert property (@(posedge clk) disable iff (rst)
    tx_wr |=> raw_q[BIT_TX]);
  a_r10_clear_bits: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !tx_wr && evt_set == '0) |=> ((raw_q & $past(wval)) == '0));
  a_r6_rx_last_pop: assert property (@(posedge clk) disable iff (rst)
    (data_rd && rx_count == CNT_W'(1) && !evt_set[BIT_RX]) |=> !raw_q[BIT_RX]);
  a_r11_quiet_when_masked: assert property (@(posedge clk) disable iff (rst)
    ($past(mask_q) == '0) |-> !irq_o);
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int IRQ_W      = 11,
  parameter int RX_W       = 12,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              bus_sel,
  input  logic                              bus_wr,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic [DATA_W-1:0]                 bus_wdata,
  output logic [DATA_W-1:0]                 bus_rdata,
  output logic                              bus_rvalid,
  output logic                              tx_strobe,
  output logic [7:0]                        tx_byte,
  input  logic                              tx_empty,
  input  logic                              tx_full,
  input  logic [RX_W-1:0]                   rx_data,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0]   rx_count,
  output logic                              rx_pop,
  input  logic [IRQ_W-1:0]                  evt_set,
  output logic                              fifo_flush,
  output logic [DATA_W-1:0]                 cfg_ilpr,
  output logic [DATA_W-1:0]                 cfg_ibrd,
  output logic [DATA_W-1:0]                 cfg_fbrd,
  output logic [DATA_W-1:0]                 cfg_lcr,
  output logic [DATA_W-1:0]                 cfg_cr,
  output logic [DATA_W-1:0]                 cfg_ifls,
  output logic [DATA_W-1:0]                 cfg_dmacr,
  output logic                              irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int ERR_W = RX_W - 8;

  logic [NUM_IDX-1:0]             wr_hit, rd_hit;
  logic                           id_hit;
  logic [2:0]                     id_sel;
  logic [NUM_CFG-1:0]             cfg_wr;
  logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q;
  logic [IRQ_W-1:0]               raw_q, mask_q;
  logic [ERR_W-1:0]               rsr_q;
  logic                           rx_full_flag, rx_empty_flag;
  logic [7:0]                     flag_byte;
  logic [DATA_W-1:0]              rd_mux;

  uart_regbank_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wr_hit(wr_hit), .rd_hit(rd_hit), .id_hit(id_hit), .id_sel(id_sel)
  );

  for (genvar c = 0; c < NUM_CFG; c++) begin : g_cfgwr
    assign cfg_wr[c] = wr_hit[cfg_index(c)];
  end

  uart_regbank_cfg #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .wdata(bus_wdata),
    .cfg_q(cfg_q), .fifo_flush(fifo_flush)
  );

  uart_regbank_irq #(.IRQ_W(IRQ_W), .CNT_W(CNT_W)) u_irq (
    .clk(clk), .rst(rst),
    .mask_wr(wr_hit[IDX_IMSC]), .clr_wr(wr_hit[IDX_ICR]),
    .tx_wr(wr_hit[IDX_DATA]), .data_rd(rd_hit[IDX_DATA]),
    .rx_count(rx_count), .evt_set(evt_set), .wval(bus_wdata[IRQ_W-1:0]),
    .raw_q(raw_q), .mask_q(mask_q), .irq_o(irq)
  );

  assign cfg_ilpr  = cfg_q[CFG_ILPR];
  assign cfg_ibrd  = cfg_q[CFG_IBRD];
  assign cfg_fbrd  = cfg_q[CFG_FBRD];
  assign cfg_lcr   = cfg_q[CFG_LCR];
  assign cfg_cr    = cfg_q[CFG_CR];
  assign cfg_ifls  = cfg_q[CFG_IFLS];
  assign cfg_dmacr = cfg_q[CFG_DMACR];

  // receive-side pop and status capture
  assign rx_pop = rd_hit[IDX_DATA] & (rx_count != '0);

  always_ff @(posedge clk) begin
    if (rst)                    rsr_q <= '0;
    else if (rd_hit[IDX_DATA])  rsr_q <= rx_data[RX_W-1:8];
    else if (wr_hit[IDX_RSR])   rsr_q <= '0;
  end

  // transmit strobe, registered
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_strobe <= 1'b0;
      tx_byte   <= '0;
    end else begin
      tx_strobe <= wr_hit[IDX_DATA];
      if (wr_hit[IDX_DATA]) tx_byte <= bus_wdata[7:0];
    end
  end

  // flag register from live FIFO status
  assign rx_empty_flag = (rx_count == '0);
  assign rx_full_flag  = cfg_q[CFG_LCR][LCR_FIFO_EN] ? (rx_count == CNT_W'(FIFO_DEPTH))
                                                      : !rx_empty_flag;
  assign flag_byte = {tx_empty, rx_full_flag, tx_full, rx_empty_flag, 4'b0000};

  always_comb begin
    rd_mux = '0;
    if (id_hit)           rd_mux = DATA_W'(id_byte(id_sel));
    if (rd_hit[IDX_DATA]) rd_mux = DATA_W'(rx_data);
    if (rd_hit[IDX_RSR])  rd_mux = DATA_W'(rsr_q);
    if (rd_hit[IDX_FLAG]) rd_mux = DATA_W'(flag_byte);
    if (rd_hit[IDX_IMSC]) rd_mux = DATA_W'(mask_q);
    if (rd_hit[IDX_RIS])  rd_mux = DATA_W'(raw_q);
    if (rd_hit[IDX_MIS])  rd_mux = DATA_W'(raw_q & mask_q);
    for (int c = 0; c < NUM_CFG; c++) begin
      if (rd_hit[cfg_index(c)]) rd_mux = cfg_q[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_sel & ~bus_wr;
      if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
    end
  end

  a_r13_rvalid_follows_read: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr) |=> bus_rvalid);
  a_r13_no_spurious_rvalid: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_wr) |=> !bus_rvalid);
  a_r8_status_cleared: assert property (@(posedge clk) disable iff (rst)
    wr_hit[IDX_RSR] |=> (rsr_q == '0));
  a_r5_tx_byte_passed: assert property (@(posedge clk) disable iff (rst)
    wr_hit[IDX_DATA] |=> (tx_strobe && tx_byte == $past(bus_wdata[7:0])));
  a_r7_pop_needs_data: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> (rx_count != '0));
endmodule

// File: tb/uart_regbank_test.sv
`timescale 1ns/1ps
module uart_regbank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, tx_strobe, rx_pop, fifo_flush, irq;
  logic [7:0]  tx_byte;
  logic        tx_empty = 1'b1, tx_full = 1'b0;
  logic [11:0] rx_data = '0;
  logic [4:0]  rx_count = '0;
  logic [10:0] evt_set = '0;
  logic [31:0] cfg_ilpr, cfg_ibrd, cfg_fbrd, cfg_lcr, cfg_cr, cfg_ifls, cfg_dmacr;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [31:0] model [0:18];
  logic [10:0] m_raw = '0, m_mask = '0;

  always #2 clk = ~clk;

  uart_regbank uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .tx_strobe(tx_strobe), .tx_byte(tx_byte), .tx_empty(tx_empty), .tx_full(tx_full),
    .rx_data(rx_data), .rx_count(rx_count), .rx_pop(rx_pop), .evt_set(evt_set),
    .fifo_flush(fifo_flush), .cfg_ilpr(cfg_ilpr), .cfg_ibrd(cfg_ibrd),
    .cfg_fbrd(cfg_fbrd), .cfg_lcr(cfg_lcr), .cfg_cr(cfg_cr), .cfg_ifls(cfg_ifls),
    .cfg_dmacr(cfg_dmacr), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_id(input int k);
    case (k)
      0: return 8'h11; 1: return 8'h10; 2: return 8'h14; 3: return 8'h00;
      4: return 8'h0D; 5: return 8'hF0; 6: return 8'h05; default: return 8'hB1;
    endcase
  endfunction

  function automatic logic [31:0] exp_flag(input logic te, input logic tf,
                                           input int cnt, input logic fen);
    logic rf;
    rf = fen ? (cnt == 16) : (cnt >= 1);
    return {24'h0, te, rf, tf, (cnt == 0), 4'h0};
  endfunction

  function automatic logic [31:0] cfg_port(input int idx);
    case (idx)
      8: return cfg_ilpr; 9: return cfg_ibrd; 10: return cfg_fbrd; 11: return cfg_lcr;
      12: return cfg_cr; 13: return cfg_ifls; default: return cfg_dmacr;
    endcase
  endfunction

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_evt(input logic [10:0] v);
    @(negedge clk);
    evt_set = v;
    @(negedge clk);
    evt_set = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 19; i++) model[i] = '0;
    model[13] = 32'h12; model[12] = 32'h300;

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R2: reset state
    bus_read(12'h018, rd); check("R2 flag reset", rd, 32'h90);
    bus_read(12'h034, rd); check("R2 level-select reset", rd, 32'h12);
    bus_read(12'h030, rd); check("R2 control reset", rd, 32'h300);
    bus_read(12'h024, rd); check("R2 int divisor reset", rd, 32'h0);
    bus_read(12'h03C, rd); check("R2 raw reset", rd, 32'h0);
    check("R2 irq reset", {31'h0, irq}, 32'h0);
    check("R13 rvalid after read", {31'h0, bus_rvalid}, 32'h1);
    @(negedge clk);
    check("R13 rvalid idle", {31'h0, bus_rvalid}, 32'h0);

    // R3: identification bytes
    for (int k = 0; k < 8; k++) begin
      bus_read(12'hFE0 + 12'(4 * k), rd);
      check("R3 id byte", rd, {24'h0, exp_id(k)});
    end
    bus_read(12'hFE1, rd); check("R3 id unaligned", rd, {24'h0, exp_id(0)});
    bus_read(12'hFFF, rd); check("R3 id last", rd, {24'h0, exp_id(7)});

    // R4: undefined offsets, ignored writes; R9 flag write ignored
    bus_read(12'h008, rd); check("R4 undefined idx2", rd, 0);
    bus_read(12'h01C, rd); check("R4 undefined idx7", rd, 0);
    bus_read(12'h800, rd); check("R4 unused space", rd, 0);
    bus_write(12'h008, 32'hFFFF_FFFF);
    bus_write(12'h03C, 32'h7FF);
    bus_write(12'h040, 32'h7FF);
    bus_write(12'h018, 32'h0);
    bus_read(12'h03C, rd); check("R4 raw unchanged", rd, 0);
    bus_read(12'h024, rd); check("R4 int divisor unchanged", rd, 0);
    bus_read(12'h008, rd); check("R4 undefined still 0", rd, 0);
    bus_read(12'h018, rd); check("R9 flag write ignored", rd, 32'h90);

    // R1: random configuration traffic
    for (int i = 0; i < 40; i++) begin
      int sel_w, sel_r;
      logic [31:0] v;
      int slots [8] = '{8, 9, 10, 11, 12, 13, 14, 18};
      sel_w = slots[$urandom_range(0, 7)];
      v = $urandom();
      if (sel_w == 11) v[4] = 1'b0;
      bus_write(12'(sel_w * 4), v);
      model[sel_w] = (sel_w == 14) ? (v & 32'h7FF) : v;
      sel_r = slots[$urandom_range(0, 7)];
      bus_read(12'(sel_r * 4), rd);
      check("R1 readback", rd, model[sel_r]);
      if (sel_w != 14) check("R1 cfg port", cfg_port(sel_w), model[sel_w]);
    end
    bus_write(12'h038, 32'h0); m_mask = '0;
    bus_write(12'h02C, 32'h0);

    // R5: transmit
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h000; bus_wdata = 32'h1A5;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    check("R5 tx strobe", {31'h0, tx_strobe}, 1);
    check("R5 tx byte", {24'h0, tx_byte}, 32'hA5);
    @(negedge clk);
    check("R5 tx strobe single", {31'h0, tx_strobe}, 0);
    m_raw[5] = 1'b1;
    bus_read(12'h03C, rd); check("R5 raw TX bit", rd, 32'h20);

    // R11: irq lag; R10 masked status and clear
    check("R11 irq masked off", {31'h0, irq}, 0);
    bus_write(12'h038, 32'h20); m_mask = 11'h20;
    check("R11 irq not yet", {31'h0, irq}, 0);
    @(negedge clk);
    check("R11 irq one cycle later", {31'h0, irq}, 1);
    bus_read(12'h040, rd); check("R10 masked status", rd, 32'h20);
    bus_write(12'h044, 32'h20); m_raw = '0;
    check("R11 irq holds one cycle", {31'h0, irq}, 1);
    @(negedge clk);
    check("R11 irq falls", {31'h0, irq}, 0);
    bus_read(12'h03C, rd); check("R10 raw cleared", rd, 0);

    // R6/R10: random events, clears and masks
    for (int i = 0; i < 20; i++) begin
      logic [10:0] e, c, m;
      e = 11'($urandom()); c = 11'($urandom()); m = 11'($urandom());
      pulse_evt(e); m_raw |= e;
      bus_read(12'h03C, rd); check("R6 raw set by events", rd, {21'h0, m_raw});
      bus_write(12'h044, {21'h0, c}); m_raw &= ~c;
      bus_write(12'h038, {21'h0, m}); m_mask = m;
      bus_read(12'h03C, rd); check("R10 raw after clear", rd, {21'h0, m_raw});
      bus_read(12'h040, rd); check("R10 masked", rd, {21'h0, m_raw & m_mask});
      check("R11 irq level", {31'h0, irq}, {31'h0, |(m_raw & m_mask)});
    end
    bus_write(12'h044, 32'h7FF); m_raw = '0;
    bus_write(12'h038, 32'h0);

    // R6/R7/R8: receive side
    rx_count = 5'd3; rx_data = 12'h5C3;
    pulse_evt(11'h010);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h000;
    #1;
    check("R7 pop when nonempty", {31'h0, rx_pop}, 1);
    @(negedge clk);
    bus_sel = 1'b0;
    check("R7 data read value", bus_rdata, 32'h5C3);
    bus_read(12'h03C, rd); check("R6 RX kept with entries left", rd, 32'h10);
    bus_read(12'h004, rd); check("R7 error flags latched", rd, 32'h5);
    bus_write(12'h004, 32'h0);
    bus_read(12'h004, rd); check("R8 status cleared", rd, 0);
    rx_count = 5'd1; rx_data = 12'h03C;
    bus_read(12'h000, rd); check("R7 data read last", rd, 32'h03C);
    bus_read(12'h03C, rd); check("R6 RX cleared on last pop", rd, 0);
    rx_count = 5'd0;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h000;
    #1;
    check("R7 no pop when empty", {31'h0, rx_pop}, 0);
    @(negedge clk);
    bus_sel = 1'b0;

    // R9/R12: flags and flush
    rx_count = 5'd1;
    bus_read(12'h018, rd); check("R9 full without fifo", rd, exp_flag(1, 0, 1, 0));
    bus_write(12'h02C, 32'h10);
    check("R12 flush on enable", {31'h0, fifo_flush}, 1);
    @(negedge clk);
    check("R12 flush single", {31'h0, fifo_flush}, 0);
    bus_read(12'h018, rd); check("R9 not full with fifo", rd, exp_flag(1, 0, 1, 1));
    rx_count = 5'd16; tx_full = 1'b1; tx_empty = 1'b0;
    bus_read(12'h018, rd); check("R9 full at depth", rd, exp_flag(0, 1, 16, 1));
    bus_write(12'h02C, 32'h70);
    check("R12 no flush when unchanged", {31'h0, fifo_flush}, 0);
    bus_write(12'h02C, 32'h60);
    check("R12 flush on disable", {31'h0, fifo_flush}, 1);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule